// File: doc/BRIEF.md
# Iterative Radix-2 Integer Multiplier

The block multiplies two 32-bit operands over 32 clock cycles. It retires one multiplier bit per cycle and uses a single adder/subtractor. One 64-bit product register holds the running partial product in its upper half. At the start, the multiplier operand sits in its lower half. Each step first updates the upper half, then shifts the whole register right by one place. The multiplier therefore drains out of the bottom while the product fills in from the top.

A mode input, sampled at the start, selects one of two treatments:

- **Unsigned shift-add:** the carry-out of each add is shifted back into the register.
- **Signed radix-2 Booth recoding:** the retiring bit is paired with the bit retired just before it. The shift carries the true sign of the add/subtract result, so no sign correction is needed at the end.

A caller pulses start while the block is idle. It then waits for the one-cycle done pulse and reads the product as a high word and a low word. Those words stay valid until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, busy_o and done_o are 0, and hi_o and lo_o are both 0.
- R2: When start_i is high while busy_o is 0, the next clock sets busy_o. In the same cycle hi_o reads 0 and lo_o reads the multiplier operand mplier_i.
- R3: After an accepted start, busy_o stays high for exactly 32 cycles, one multiplier bit per cycle.
- R4: done_o is high for exactly one cycle, namely the first cycle in which busy_o has returned to 0.
- R5: With mode_i = 0 (unsigned), the result {hi_o, lo_o} equals the 64-bit product of the two operands read as unsigned numbers. The carry-out of each add is kept, so 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R6: With mode_i = 1 (signed Booth), the result equals the 64-bit two's-complement product. The retiring bit and the bit retired just before it select the action: 10 subtracts the multiplicand, 01 adds it, and 00 or 11 leaves the upper half unchanged. The previously retired bit is 0 before the first step.
- R7: In signed mode the most negative operand 0x80000000 is handled exactly. 0x80000000 times itself gives 0x4000000000000000, and 0x80000000 times 0xFFFFFFFF gives 0x0000000080000000.
- R8: A start_i pulse while busy_o is 1 has no effect on the run in progress or on its result.
- R9: While idle and with no start, hi_o and lo_o hold the last result.
- R10: hi_o carries bits 63..32 of the product and lo_o carries bits 31..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when idle |
| mode_i | input | 1 | 0 = unsigned shift-add, 1 = signed Booth |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper product word |
| lo_o | output | 32 | Lower product word |

## Verification
The bench targets the cases where a loose implementation breaks:

- **Unsigned all-ones squared:** a design that drops the add carry loses the top bit of every partial sum.
- **Signed most-negative operand times itself and times -1:** with a plain 32-bit arithmetic shift, subtracting 0x80000000 overflows, and the wrong sign gets replicated.
- **Alternating bit patterns:** these exercise every Booth pair transition and would expose a swapped add/subtract or a wrong initial previous bit.
- **Start pulse in the middle of a run:** a block that re-arms on that pulse would restart the count or corrupt the operands.

Step count and the done timing are compared on every cycle, so an off-by-one iteration count shows up as a busy or done mismatch.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } op_e;

  typedef enum logic {
    MODE_UNS   = 1'b0,
    MODE_BOOTH = 1'b1
  } mode_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/mul_recode.sv
module mul_recode
  import mul_pkg::*;
(
  input  mode_e mode_i,
  input  logic  cur_i,
  input  logic  prev_i,
  output op_e   op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (mode_i == MODE_UNS) begin
      if (cur_i) op_o = OP_ADD;
    end else begin
      unique case ({cur_i, prev_i})
        2'b10:   op_o = OP_SUB;
        2'b01:   op_o = OP_ADD;
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mul_addsub.sv
module mul_addsub
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  mode_e        mode_i,
  input  op_e          op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mcand_i,
  output logic [W:0]   res_o
);
  logic       ext_a, ext_b, sub;
  logic [W:0] opa, opb;

  // extension bit: carry slot for unsigned, true sign for Booth
  assign ext_a = (mode_i == MODE_BOOTH) ? acc_i[W-1] : 1'b0;
  assign ext_b = (mode_i == MODE_BOOTH) ? mcand_i[W-1] : 1'b0;
  assign sub   = (op_i == OP_SUB);
  assign opa   = {ext_a, acc_i};
  assign opb   = (op_i == OP_NONE) ? '0 : ({ext_b, mcand_i} ^ {(W+1){sub}});

  assign res_o = opa + opb + {{W{1'b0}}, sub};
endmodule

// File: rtl/mul_prod_reg.sv
module mul_prod_reg
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         mode_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  input  logic [W:0]   res_i,
  output mode_e        mode_o,
  output logic [W-1:0] mcand_o,
  output logic [W-1:0] acc_o,
  output logic         cur_o,
  output logic         prev_o,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] prod_q;
  logic           prev_q;
  logic [W-1:0]   mcand_q;
  mode_e          mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      prev_q  <= 1'b0;
      mcand_q <= '0;
      mode_q  <= MODE_UNS;
    end else if (load_i) begin
      prod_q  <= {{W{1'b0}}, mplier_i};
      prev_q  <= 1'b0;
      mcand_q <= mcand_i;
      mode_q  <= mode_e'(mode_i);
    end else if (step_i) begin
      // new upper half plus extension bit, lower half shifts down
      prod_q <= {res_i, prod_q[W-1:1]};
      prev_q <= prod_q[0];
    end
  end

  assign mode_o  = mode_q;
  assign mcand_o = mcand_q;
  assign acc_o   = prod_q[2*W-1:W];
  assign cur_o   = prod_q[0];
  assign prev_o  = prev_q;
  assign prod_o  = prod_q;
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic           load, step, cur, prev;
  mode_e          mode_q;
  op_e            op;
  logic [W-1:0]   mcand_q, acc;
  logic [W:0]     res;
  logic [2*W-1:0] prod;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_recode u_rec (
    .mode_i(mode_q),
    .cur_i (cur),
    .prev_i(prev),
    .op_o  (op)
  );

  mul_addsub #(.W(W)) u_alu (
    .mode_i (mode_q),
    .op_i   (op),
    .acc_i  (acc),
    .mcand_i(mcand_q),
    .res_o  (res)
  );

  mul_prod_reg #(.W(W)) u_prod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mode_i  (mode_i),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .res_i   (res),
    .mode_o  (mode_q),
    .mcand_o (mcand_q),
    .acc_o   (acc),
    .cur_o   (cur),
    .prev_o  (prev),
    .prod_o  (prod)
  );

  assign hi_o = prod[2*W-1:W];
  assign lo_o = prod[W-1:0];
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] mplier_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int LW = $clog2(W) + 2;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_len <= '0;
    else         run_len <= busy_o ? run_len + 1'b1 : '0;
  end

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && hi_o == '0 && lo_o == $past(mplier_i)));

  // R3
  run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_len < LW'(W)));

  // R3
  end_on_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len == LW'(W)));

  // R4
  fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable({hi_o, lo_o}));
endmodule

bind booth_seq_mult mul_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .mplier_i(mplier_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/sim_booth_seq_mult.sv
module sim_booth_seq_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  booth_seq_mult u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .mcand_i(a), .mplier_i(b), .busy_o(busy), .done_o(done),
    .hi_o(hi), .lo_o(lo)
  );

  // behavioural reference
  logic        m_busy, m_done, m_load, m_mode, m_minneg;
  int          m_cnt;
  logic [63:0] m_exp;
  logic [31:0] m_b;
  logic        ign_phase = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_load <= 0; m_cnt <= 0;
      m_exp <= '0; m_b <= '0; m_mode <= 0; m_minneg <= 0;
    end else begin
      m_done <= 0;
      m_load <= 0;
      if (m_busy) begin
        if (m_cnt == 31) begin m_busy <= 0; m_done <= 1; end
        m_cnt <= m_cnt + 1;
      end else if (start) begin
        m_busy <= 1; m_cnt <= 0; m_load <= 1; m_b <= b; m_mode <= mode;
        m_minneg <= (a == 32'h8000_0000) || (b == 32'h8000_0000);
        if (mode) m_exp <= 64'(longint'(signed'(a)) * longint'(signed'(b)));
        else      m_exp <= {32'b0, a} * {32'b0, b};
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string res_tag();
    if (ign_phase) return "R8";
    if (m_minneg && m_mode) return "R7";
    return m_mode ? "R6" : "R5";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R3 busy", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R4 done", 64'(done), 64'(m_done));
      if (m_load)
        chk({hi, lo} == {32'b0, m_b}, "R2 load", {hi, lo}, {32'b0, m_b});
      if (m_done) begin
        chk({hi, lo} == m_exp, res_tag(), {hi, lo}, m_exp);
        chk(hi == m_exp[63:32], "R10 hi", 64'(hi), 64'(m_exp[63:32]));
        chk(lo == m_exp[31:0], "R10 lo", 64'(lo), 64'(m_exp[31:0]));
      end else if (!m_busy) begin
        chk({hi, lo} == m_exp, (m_exp == 0 && m_b == 0) ? "R1 idle" : "R9 hold",
            {hi, lo}, m_exp);
      end
    end
  end

  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic md);
    @(negedge clk);
    a = x; b = y; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);
  endtask

  initial begin
    repeat (1000) @(negedge clk);
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    n_bad++; n_cmp++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(!busy && !done && hi == 0 && lo == 0, "R1", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(32'd0, 32'd0, 1'b0);
    run(32'd1, 32'd1, 1'b0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);       // R5 carry
    run(32'h8000_0000, 32'h8000_0000, 1'b0);
    run(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    run(32'hFFFF_FFFE, 32'd7, 1'b1);               // R6 -2*7
    run(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);       // R6 alternating pairs
    run(32'h1234_5678, 32'hF0F0_0F0F, 1'b1);
    run(32'h8000_0000, 32'h8000_0000, 1'b1);       // R7
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);       // R7
    run(32'hFFFF_FFFF, 32'h8000_0000, 1'b1);       // R7
    run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);       // R7
    s = 32'h1ACE_B00C;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] t;
      s = s * 32'd1664525 + 32'd1013904223;
      t = s ^ (s << 7);
      run(s, t, 1'(i));
    end
    // R8: extra start in mid-run with other operands
    ign_phase = 1'b1;
    @(negedge clk);
    a = 32'd12345; b = 32'hFFFF_FF00; mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    a = 32'hDEAD_BEEF; b = 32'h0BAD_F00D; mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    ign_phase = 1'b0;
    repeat (5) @(negedge clk);                     // R9 hold while idle
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule